// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This combinational block resolves one control-transfer instruction per evaluation. It takes the current program counter, the two register operand values, the 16-bit branch displacement, the 26-bit jump index, the destination register field and a decoded operation code. From these it reports whether control leaves the sequential path, the address it goes to, and whether a return address must be written, to which register and with which value.

It handles the two-register equality branches and the four signed zero-compare branches. It handles the two zero-compare branches that also link. It handles the region-relative absolute jump, with and without link. It handles the register-indirect jump, with and without link; the linking form takes its destination register from the instruction. Fetch, delay-slot sequencing and hazard handling sit outside the block. The link value already accounts for the slot after the transfer.

Top module: `ctl_resolve`

## Requirements
- R1: The operation code on `op_sel` is 4 bits wide: 0 none, 1 equal-branch, 2 unequal-branch, 3 branch if >= 0, 4 branch if > 0, 5 branch if <= 0, 6 branch if < 0, 7 link-branch if >= 0, 8 link-branch if < 0, 9 absolute jump, 10 absolute jump with link, 11 register jump, 12 register jump with link. Code 0 and codes 13 to 15 give `taken`=0, `link_en`=0 and `target` = pc+4.
- R2: The equal-branch is taken exactly when `rs_val` equals `rt_val`, and the unequal-branch exactly when they differ in any bit.
- R3: Codes 3 to 6 treat `rs_val` as a signed two's-complement number and are taken when it is >= 0, > 0, <= 0 and < 0 respectively.
- R4: For codes 1 to 8, `target` is pc+4 plus the sign-extended displacement shifted left by two, modulo 2^32. It is reported whether or not the branch is taken.
- R5: Codes 7 and 8 are taken under the same rule as codes 3 and 6. They always assert `link_en` with `link_reg` = 31, whether taken or not.
- R6: Codes 9 and 10 are always taken. Their target is pc[31:28] followed by `jump_idx` followed by two zero bits.
- R7: Code 10 asserts `link_en` with `link_reg` = 31. Codes 1 to 6, 9 and 11 never assert `link_en`.
- R8: Code 11 is always taken, with `target` equal to all 32 bits of `rs_val`.
- R9: Code 12 is always taken with `target` = `rs_val`. It asserts `link_en` with `link_reg` equal to `rd_idx`, whatever value `rd_idx` holds (31 when the instruction named no register).
- R10: Whenever `link_en` is 1, `link_val` is pc+8 modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc | input | 32 | Address of the control-transfer instruction |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| br_disp | input | 16 | Signed branch displacement in words |
| jump_idx | input | 26 | Word index for the absolute jump |
| rd_idx | input | 5 | Destination register field of the instruction |
| op_sel | input | 4 | Decoded operation code (see R1) |
| taken | output | 1 | Control leaves the sequential path |
| target | output | 32 | Resolved destination address |
| link_en | output | 1 | A return address must be written |
| link_reg | output | 5 | Register receiving the return address |
| link_val | output | 32 | Return address |

## Verification
The two linking branches decide the branch and produce a link write in the same evaluation. The link must appear even when the condition fails. The bench provokes this with directed cases at the sign boundary, where `rs_val` is zero, minus one or the most negative value. It also biases random operands towards those values. For each case the bench compares `taken` and `target` with its own condition and address model, and separately requires `link_en`, `link_reg` = 31 and `link_val` = pc+8, independent of the decision. Register-linked jumps are judged the same way, with `rd_idx` varied, including 0 and 31.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
   typedef enum logic [3:0] {
      OP_NONE   = 4'd0,
      OP_BEQ    = 4'd1,
      OP_BNE    = 4'd2,
      OP_BGEZ   = 4'd3,
      OP_BGTZ   = 4'd4,
      OP_BLEZ   = 4'd5,
      OP_BLTZ   = 4'd6,
      OP_BGEZAL = 4'd7,
      OP_BLTZAL = 4'd8,
      OP_J      = 4'd9,
      OP_JAL    = 4'd10,
      OP_JR     = 4'd11,
      OP_JALR   = 4'd12
   } ctl_op_e;

   function automatic logic is_branch(input logic [3:0] op);
      return (op >= 4'd1) && (op <= 4'd8);
   endfunction
endpackage

// File: rtl/ctl_cond.sv
module ctl_cond
   import ctl_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter bit EQ_XOR_TREE = 1'b1
) (
   input  logic [3:0]      op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic            taken
);
   logic eq;
   logic neg;
   logic zero;

   generate
      if (EQ_XOR_TREE) begin : g_eq_xor
         assign eq = ~|(a ^ b);
      end else begin : g_eq_cmp
         assign eq = (a == b);
      end
   endgenerate

   assign neg  = a[XLEN-1];
   assign zero = ~|a;

   always_comb begin
      unique case (op)
         OP_BEQ:                      taken = eq;
         OP_BNE:                      taken = ~eq;
         OP_BGEZ, OP_BGEZAL:          taken = ~neg;
         OP_BGTZ:                     taken = ~neg & ~zero;
         OP_BLEZ:                     taken = neg | zero;
         OP_BLTZ, OP_BLTZAL:          taken = neg;
         OP_J, OP_JAL, OP_JR, OP_JALR: taken = 1'b1;
         default:                     taken = 1'b0;
      endcase
   end
endmodule

// File: rtl/ctl_target.sv
module ctl_target
   import ctl_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int OFF_W = 16,
   parameter int IDX_W = 26
) (
   input  logic [3:0]       op,
   input  logic [XLEN-1:0]  pc,
   input  logic [XLEN-1:0]  a,
   input  logic [OFF_W-1:0] off,
   input  logic [IDX_W-1:0] idx,
   output logic [XLEN-1:0]  target
);
   localparam int RGN_W = XLEN - IDX_W - 2;
   localparam int EXT_W = XLEN - OFF_W - 2;

   generate
      if (RGN_W < 1) begin : g_bad_idx
         $error("ctl_target: IDX_W+2 must be below XLEN");
      end
      if (EXT_W < 0) begin : g_bad_off
         $error("ctl_target: OFF_W+2 must not exceed XLEN");
      end
   endgenerate

   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] disp;
   logic [XLEN-1:0] br_tgt;
   logic [XLEN-1:0] abs_tgt;

   assign seq_pc  = pc + XLEN'(4);
   assign disp    = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
   assign br_tgt  = seq_pc + disp;
   assign abs_tgt = {pc[XLEN-1 -: RGN_W], idx, 2'b00};

   always_comb begin
      if (is_branch(op))                      target = br_tgt;
      else if (op == OP_J || op == OP_JAL)    target = abs_tgt;
      else if (op == OP_JR || op == OP_JALR)  target = a;
      else                                    target = seq_pc;
   end
endmodule

// File: rtl/ctl_link.sv
module ctl_link
   import ctl_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int REG_W    = 5,
   parameter int LINK_REG = 31
) (
   input  logic [3:0]       op,
   input  logic [XLEN-1:0]  pc,
   input  logic [REG_W-1:0] rd,
   output logic             link_en,
   output logic [REG_W-1:0] link_reg,
   output logic [XLEN-1:0]  link_val
);
   generate
      if (LINK_REG >= (1 << REG_W)) begin : g_bad_link
         $error("ctl_link: LINK_REG does not fit in REG_W");
      end
   endgenerate

   assign link_val = pc + XLEN'(8);

   always_comb begin
      link_en  = 1'b0;
      link_reg = REG_W'(LINK_REG);
      unique case (op)
         OP_BGEZAL, OP_BLTZAL, OP_JAL: link_en = 1'b1;
         OP_JALR: begin
            link_en  = 1'b1;
            link_reg = rd;
         end
         default: link_en = 1'b0;
      endcase
   end
endmodule

// File: rtl/ctl_resolve.sv
module ctl_resolve
   import ctl_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int OFF_W       = 16,
   parameter int IDX_W       = 26,
   parameter int REG_W       = 5,
   parameter int LINK_REG    = 31,
   parameter bit EQ_XOR_TREE = 1'b1
) (
   input  logic [XLEN-1:0]  pc,
   input  logic [XLEN-1:0]  rs_val,
   input  logic [XLEN-1:0]  rt_val,
   input  logic [OFF_W-1:0] br_disp,
   input  logic [IDX_W-1:0] jump_idx,
   input  logic [REG_W-1:0] rd_idx,
   input  logic [3:0]       op_sel,
   output logic             taken,
   output logic [XLEN-1:0]  target,
   output logic             link_en,
   output logic [REG_W-1:0] link_reg,
   output logic [XLEN-1:0]  link_val
);
   localparam int RGN_W = XLEN - IDX_W - 2;

   ctl_cond #(.XLEN(XLEN), .EQ_XOR_TREE(EQ_XOR_TREE)) u_cond (
      .op(op_sel), .a(rs_val), .b(rt_val), .taken(taken)
   );

   ctl_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
      .op(op_sel), .pc(pc), .a(rs_val), .off(br_disp), .idx(jump_idx),
      .target(target)
   );

   ctl_link #(.XLEN(XLEN), .REG_W(REG_W), .LINK_REG(LINK_REG)) u_link (
      .op(op_sel), .pc(pc), .rd(rd_idx),
      .link_en(link_en), .link_reg(link_reg), .link_val(link_val)
   );

   always_comb begin
      if (op_sel == OP_NONE || op_sel > OP_JALR) begin
         p_idle_quiet_r1: assert (!taken && !link_en && target == pc + XLEN'(4))
            else $error("idle code produced activity");
      end
      if (op_sel == OP_J || op_sel == OP_JAL) begin
         p_region_keep_r6: assert (taken && target[XLEN-1 -: RGN_W] == pc[XLEN-1 -: RGN_W])
            else $error("absolute jump left its region");
      end
      if (link_en && op_sel != OP_JALR) begin
         p_link_fixed_r7: assert (link_reg == REG_W'(LINK_REG))
            else $error("fixed link register wrong");
      end
      if (link_en) begin
         p_link_skip_r10: assert (link_val - pc == XLEN'(8))
            else $error("link value does not skip the slot");
      end
      if (op_sel == OP_JR || op_sel == OP_JALR) begin
         p_reg_jump_r8: assert (taken && target == rs_val)
            else $error("register jump target wrong");
      end
      if (op_sel == OP_BGEZAL || op_sel == OP_BLTZAL) begin
         p_link_always_r5: assert (link_en)
            else $error("linking branch dropped its link");
      end
   end
endmodule

// File: tb/sim_ctl_resolve.sv
module sim_ctl_resolve;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc, rs_val, rt_val;
   logic [15:0] br_disp;
   logic [25:0] jump_idx;
   logic [4:0]  rd_idx;
   logic [3:0]  op_sel;
   logic        taken, link_en;
   logic [31:0] target, link_val;
   logic [4:0]  link_reg;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   ctl_resolve u0 (
      .pc(pc), .rs_val(rs_val), .rt_val(rt_val), .br_disp(br_disp),
      .jump_idx(jump_idx), .rd_idx(rd_idx), .op_sel(op_sel),
      .taken(taken), .target(target), .link_en(link_en),
      .link_reg(link_reg), .link_val(link_val)
   );

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd1, 4'd2:           return "R2";
         4'd3, 4'd4, 4'd5, 4'd6: return "R3";
         4'd7, 4'd8:           return "R5";
         4'd9, 4'd10:          return "R6";
         4'd11:                return "R8";
         4'd12:                return "R9";
         default:              return "R1";
      endcase
   endfunction

   function automatic logic exp_taken(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
      logic signed [31:0] s;
      s = a;
      case (op)
         4'd1: return a == b;
         4'd2: return a != b;
         4'd3, 4'd7: return s >= 0;
         4'd4: return s > 0;
         4'd5: return s <= 0;
         4'd6, 4'd8: return s < 0;
         4'd9, 4'd10, 4'd11, 4'd12: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] exp_target(input logic [3:0] op, input logic [31:0] p,
                                              input logic [31:0] a, input logic [15:0] d,
                                              input logic [25:0] j);
      logic signed [31:0] sd;
      sd = 32'(signed'(d)) * 4;
      if (op >= 4'd1 && op <= 4'd8) return p + 32'd4 + sd;
      if (op == 4'd9 || op == 4'd10) return (p & 32'hF000_0000) | (32'(j) << 2);
      if (op == 4'd11 || op == 4'd12) return a;
      return p + 32'd4;
   endfunction

   function automatic logic exp_link(input logic [3:0] op);
      return op == 4'd7 || op == 4'd8 || op == 4'd10 || op == 4'd12;
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [31:0] p, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] d, input logic [25:0] j,
                        input logic [4:0] rd);
      string t;
      @(negedge clk);
      op_sel = op; pc = p; rs_val = a; rt_val = b; br_disp = d; jump_idx = j; rd_idx = rd;
      @(posedge clk);
      #2;
      t = tag_of(op);
      check(t, "taken", 32'(taken), 32'(exp_taken(op, a, b)));
      check((op >= 4'd1 && op <= 4'd8) ? "R4" : t, "target", target, exp_target(op, p, a, d, j));
      check((op == 4'd1 || op == 4'd2 || op == 4'd9 || op == 4'd11 || (op >= 4'd3 && op <= 4'd6)) ? "R7" : t,
            "link_en", 32'(link_en), 32'(exp_link(op)));
      if (exp_link(op)) begin
         check(t, "link_reg", 32'(link_reg), (op == 4'd12) ? 32'(rd) : 32'd31);
         check("R10", "link_val", link_val, p + 32'd8);
      end
   endtask

   initial begin
      void'($urandom(32'd2024));
      op_sel = 4'd0; pc = 32'h0000_1000; rs_val = '0; rt_val = '0;
      br_disp = '0; jump_idx = '0; rd_idx = '0;
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      #2;
      // R1: quiet idle state after start
      check("R1", "idle taken", 32'(taken), 32'd0);
      check("R1", "idle link_en", 32'(link_en), 32'd0);
      check("R1", "idle target", target, 32'h0000_1004);
      // R1: undefined codes behave as idle
      apply(4'd13, 32'h10, 32'h5, 32'h5, 16'h1, 26'h1, 5'd3);
      apply(4'd15, 32'h20, 32'h0, 32'h0, 16'h1, 26'h1, 5'd3);
      // R2: equality, differing only in msb
      apply(4'd1, 32'h400, 32'h8000_0001, 32'h8000_0001, 16'h0010, 26'h0, 5'd0);
      apply(4'd1, 32'h400, 32'h8000_0001, 32'h0000_0001, 16'h0010, 26'h0, 5'd0);
      apply(4'd2, 32'h400, 32'h8000_0001, 32'h0000_0001, 16'h0010, 26'h0, 5'd0);
      // R3: sign boundaries
      apply(4'd3, 32'h400, 32'h0, 32'h0, 16'h0003, 26'h0, 5'd0);
      apply(4'd3, 32'h400, 32'h8000_0000, 32'h0, 16'h0003, 26'h0, 5'd0);
      apply(4'd4, 32'h400, 32'h0, 32'h0, 16'h0003, 26'h0, 5'd0);
      apply(4'd5, 32'h400, 32'h0, 32'h0, 16'h0003, 26'h0, 5'd0);
      apply(4'd6, 32'h400, 32'hFFFF_FFFF, 32'h0, 16'h0003, 26'h0, 5'd0);
      // R4: negative displacement and wrap
      apply(4'd1, 32'h0000_0010, 32'h1, 32'h1, 16'h8000, 26'h0, 5'd0);
      apply(4'd2, 32'hFFFF_FFF8, 32'h1, 32'h1, 16'h0004, 26'h0, 5'd0);
      // R5: linking branch, not taken and taken
      apply(4'd8, 32'h2000, 32'h0, 32'h0, 16'h0008, 26'h0, 5'd9);
      apply(4'd8, 32'h2000, 32'h8000_0000, 32'h0, 16'h0008, 26'h0, 5'd9);
      apply(4'd7, 32'h2000, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 26'h0, 5'd9);
      // R6 R7: region jumps near region edge
      apply(4'd9, 32'h0FFF_FFFC, 32'h0, 32'h0, 16'h0, 26'h3FF_FFFF, 5'd4);
      apply(4'd10, 32'hF000_0000, 32'h0, 32'h0, 16'h0, 26'h000_0001, 5'd4);
      // R8 R9: register jumps, rd 0 / 7 / 31
      apply(4'd11, 32'h3000, 32'hDEAD_BEEF, 32'h0, 16'h0, 26'h0, 5'd7);
      apply(4'd12, 32'h3000, 32'h1234_5678, 32'h0, 16'h0, 26'h0, 5'd7);
      apply(4'd12, 32'h3000, 32'h1234_5678, 32'h0, 16'h0, 26'h0, 5'd0);
      apply(4'd12, 32'h3000, 32'h1234_5678, 32'h0, 16'h0, 26'h0, 5'd31);
      // R10: link value wraps
      apply(4'd10, 32'hFFFF_FFF8, 32'h0, 32'h0, 16'h0, 26'h5, 5'd0);
      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic [3:0]  op;
         logic [31:0] a, b;
         op = 4'($urandom_range(0, 15));
         case ($urandom_range(0, 4))
            0: a = 32'h0;
            1: a = 32'hFFFF_FFFF;
            2: a = 32'h8000_0000;
            default: a = $urandom;
         endcase
         b = ($urandom_range(0, 2) == 0) ? a : $urandom;
         apply(op, $urandom, a, b, 16'($urandom), 26'($urandom), 5'($urandom));
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule